// File: doc/BRIEF.md
# Static Memory Read-Cycle Timing Generator

This block runs read cycles on an external asynchronous static memory. A requester hands over a chip-select number, a word address and byte enables through a valid/ready request port. The block then drives the address, the active-low byte selects, one of four active-low chip selects and a shared active-low read strobe, and it samples the 32-bit data bus at a fixed point in the cycle. At the end of the cycle it returns the data with a one-clock done pulse.

Each chip select has its own timing, given on static configuration ports as whole clock counts. There is a setup and a pulse length for the read strobe, a setup and a pulse length for the chip-select strobe, and one total cycle length shared by both. Neither hold time is programmed. Each one is whatever the cycle length leaves after that strobe's setup and pulse. A request is taken while the block is idle or in the last clock of the current cycle, so cycles can run back to back. With zero setup and zero hold the strobes stay low across consecutive reads. A timing set that cannot work is flagged on the response and no strobe is driven for it.

The request port follows valid/ready rules. The requester keeps its fields steady while `req_valid` is high, and a transfer happens on a clock edge where both `req_valid` and `req_ready` are high. The response is a plain done pulse with no back-pressure: `rsp_data` and `rsp_err` are valid only in the clock where `rsp_valid` is high, and the consumer must take them then.

Top module: `smc_read_timer`

## Requirements
- R1: During reset and after it, `mem_rd_n` is 1, `mem_cs_n` is 4'hF, `mem_be_n` is 4'hF, `rsp_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 when no cycle is running and in the last clock of a cycle, and 0 in every other clock. A request is accepted on an edge where `req_valid` and `req_ready` are both 1.
- R3: The clock after acceptance is cycle index k=0. `mem_rd_n` is 0 exactly for RS <= k < RS+RP, where RS is the read setup and RP is the read pulse of the selected chip select.
- R4: Bit i of `mem_cs_n` belongs to `req_cs`=i. The selected bit is 0 exactly for CS <= k < CS+CP, where CS is the chip-select setup and CP is the chip-select pulse. All other bits stay 1, and at most one bit is 0 in any clock.
- R5: A legal cycle lasts exactly CY clocks (k=0..CY-1), where CY is the cycle length of the selected chip select. The read hold is therefore CY-RS-RP and the chip-select hold is CY-CS-CP.
- R6: In every clock of a legal cycle, `mem_addr` equals the accepted `req_addr` and `mem_be_n` equals the bitwise inverse of `req_be`. `mem_be_n` is 4'hF when no legal cycle is running.
- R7: `mem_rdata` is sampled at the end of clock k=RS+RP-1. In the clock after the last clock of the cycle, `rsp_valid` is 1 for one clock, with that data on `rsp_data` and `rsp_err`=0.
- R8: A request accepted in the last clock of a cycle starts its k=0 in the very next clock. With zero setup and zero hold on both strobes, `mem_rd_n` and the selected `mem_cs_n` bit stay 0 with no high clock between consecutive reads.
- R9: Each chip select uses only its own five timing fields, taken from slot `req_cs` of the configuration ports. Slot i sits at bits [6i+5:6i] of each 24-bit field.
- R10: A request is illegal if RP=0, CP=0, CY<RS+RP or CY<CS+CP. An illegal request occupies one clock in which `mem_rd_n` is 1 and `mem_cs_n` and `mem_be_n` are 4'hF. It is followed by a done pulse with `rsp_err`=1 and `rsp_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing is counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd_setup | input | 24 | Read-strobe setup per chip select, 6 bits per slot |
| cfg_rd_pulse | input | 24 | Read-strobe pulse per chip select, 6 bits per slot |
| cfg_cs_setup | input | 24 | Chip-select setup per chip select, 6 bits per slot |
| cfg_cs_pulse | input | 24 | Chip-select pulse per chip select, 6 bits per slot |
| cfg_cycle | input | 24 | Total read-cycle length per chip select, 6 bits per slot |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request in this clock |
| req_cs | input | 2 | Chip select of the request |
| req_addr | input | 24 | Word address (byte address bits 25 down to 2) |
| req_be | input | 4 | Active-high byte enables |
| mem_addr | output | 24 | Address to the memory |
| mem_be_n | output | 4 | Active-low byte selects |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_rdata | input | 32 | Data bus from the memory |
| rsp_valid | output | 1 | One-clock done pulse |
| rsp_data | output | 32 | Captured read data |
| rsp_err | output | 1 | Request had an illegal timing set |

## Verification
The bench runs isolated reads, back-to-back reads on one chip select, and back-to-back reads that change chip select. Together these separate a cycle that ends one clock early or late from a correct one, and a hand-over that inserts an idle clock from one that does not. Zero setup and zero hold on both strobes checks for a break in the strobes at cycle boundaries. Asymmetric settings, where the chip select leads or trails the read strobe, show whether each strobe uses its own setup and pulse. The bench drives junk on the data bus in every clock except the sampling clock, so sampling one clock off gives wrong data. Illegal sets mixed with legal ones check that the error path neither drives a strobe nor disturbs the cycle after it. Seeded random timing sets and request streams then cover many more combinations.

// File: rtl/smc_rd_pkg.sv
package smc_rd_pkg;
  // width of every timing count (clock cycles)
  localparam int unsigned TIME_W = 6;

  typedef logic [TIME_W-1:0] tcount_t;

  // one strobe: delay from cycle start, then low time
  typedef struct packed {
    tcount_t setup;
    tcount_t pulse;
  } strobe_t;

  // full timing set of one chip select
  typedef struct packed {
    strobe_t rd;
    strobe_t cs;
    tcount_t cycle;
  } rd_timing_t;
endpackage

// File: rtl/smc_rd_cfg_sel.sv
module smc_rd_cfg_sel
  import smc_rd_pkg::*;
#(
  parameter int unsigned NCS  = 4,
  localparam int unsigned SELW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int unsigned FW   = NCS * TIME_W
) (
  input  logic [FW-1:0]   cfg_rd_setup,
  input  logic [FW-1:0]   cfg_rd_pulse,
  input  logic [FW-1:0]   cfg_cs_setup,
  input  logic [FW-1:0]   cfg_cs_pulse,
  input  logic [FW-1:0]   cfg_cycle,
  input  logic [SELW-1:0] sel,
  output rd_timing_t      tim,
  output logic            bad
);
  rd_timing_t slot [NCS];

  for (genvar i = 0; i < NCS; i++) begin : g_slot
    assign slot[i].rd.setup = cfg_rd_setup[i*TIME_W +: TIME_W];
    assign slot[i].rd.pulse = cfg_rd_pulse[i*TIME_W +: TIME_W];
    assign slot[i].cs.setup = cfg_cs_setup[i*TIME_W +: TIME_W];
    assign slot[i].cs.pulse = cfg_cs_pulse[i*TIME_W +: TIME_W];
    assign slot[i].cycle    = cfg_cycle[i*TIME_W +: TIME_W];
  end

  assign tim = slot[sel];

  // ends computed one bit wider so the sum cannot wrap
  logic [TIME_W:0] rd_end, cs_end, cyc_w;
  always_comb begin
    rd_end = {1'b0, tim.rd.setup} + {1'b0, tim.rd.pulse};
    cs_end = {1'b0, tim.cs.setup} + {1'b0, tim.cs.pulse};
    cyc_w  = {1'b0, tim.cycle};
    bad    = (tim.rd.pulse == '0) || (tim.cs.pulse == '0) ||
             (cyc_w < rd_end) || (cyc_w < cs_end);
  end
endmodule

// File: rtl/smc_rd_strobe.sv
module smc_rd_strobe
  import smc_rd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    on,      // next clock belongs to a legal cycle for this strobe
  input  tcount_t k,       // next clock's cycle index
  input  strobe_t tim,
  output logic    strobe_n
);
  logic [TIME_W:0] k_w, lo_w, hi_w;
  logic            in_win;

  always_comb begin
    k_w    = {1'b0, k};
    lo_w   = {1'b0, tim.setup};
    hi_w   = {1'b0, tim.setup} + {1'b0, tim.pulse};
    in_win = on && (k_w >= lo_w) && (k_w < hi_w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_n <= 1'b1;
    else        strobe_n <= !in_win;
  end
endmodule

// File: rtl/smc_read_timer.sv
module smc_read_timer
  import smc_rd_pkg::*;
#(
  parameter int unsigned NCS    = 4,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SELW  = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned FW    = NCS * TIME_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FW-1:0]     cfg_rd_setup,
  input  logic [FW-1:0]     cfg_rd_pulse,
  input  logic [FW-1:0]     cfg_cs_setup,
  input  logic [FW-1:0]     cfg_cs_pulse,
  input  logic [FW-1:0]     cfg_cycle,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SELW-1:0]   req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BE_W-1:0]   mem_be_n,
  output logic [NCS-1:0]    mem_cs_n,
  output logic              mem_rd_n,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err
);
  // ---------------- timing selection and legality ----------------
  rd_timing_t tim_pick;
  logic       bad_pick;

  smc_rd_cfg_sel #(.NCS(NCS)) i_cfg_sel (
    .cfg_rd_setup (cfg_rd_setup),
    .cfg_rd_pulse (cfg_rd_pulse),
    .cfg_cs_setup (cfg_cs_setup),
    .cfg_cs_pulse (cfg_cs_pulse),
    .cfg_cycle    (cfg_cycle),
    .sel          (req_cs),
    .tim          (tim_pick),
    .bad          (bad_pick)
  );

  // ---------------- cycle sequencer ----------------
  logic            busy_q, busy_n;
  logic            err_q, err_n;
  tcount_t         k_q, k_n;
  tcount_t         last_q, last_n;
  tcount_t         cap_q, cap_n;
  logic [SELW-1:0] sel_q, sel_n;
  strobe_t         rd_q, rd_n_t, cs_q, cs_n_t;
  logic            accept, at_end, drive_n;

  assign at_end    = busy_q && (k_q == last_q);
  assign req_ready = !busy_q || at_end;
  assign accept    = req_valid && req_ready;

  always_comb begin
    busy_n = busy_q;
    err_n  = err_q;
    k_n    = k_q;
    last_n = last_q;
    cap_n  = cap_q;
    sel_n  = sel_q;
    rd_n_t = rd_q;
    cs_n_t = cs_q;
    if (accept) begin
      busy_n = 1'b1;
      err_n  = bad_pick;
      k_n    = '0;
      last_n = bad_pick ? '0 : tim_pick.cycle - tcount_t'(1);
      cap_n  = tim_pick.rd.setup + tim_pick.rd.pulse - tcount_t'(1);
      sel_n  = req_cs;
      rd_n_t = tim_pick.rd;
      cs_n_t = tim_pick.cs;
    end else if (at_end) begin
      busy_n = 1'b0;
      k_n    = '0;
    end else if (busy_q) begin
      k_n    = k_q + tcount_t'(1);
    end
  end

  assign drive_n = busy_n && !err_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      k_q    <= '0;
      last_q <= '0;
      cap_q  <= '0;
      sel_q  <= '0;
      rd_q   <= '0;
      cs_q   <= '0;
    end else begin
      busy_q <= busy_n;
      err_q  <= err_n;
      k_q    <= k_n;
      last_q <= last_n;
      cap_q  <= cap_n;
      sel_q  <= sel_n;
      rd_q   <= rd_n_t;
      cs_q   <= cs_n_t;
    end
  end

  // ---------------- strobe generators ----------------
  smc_rd_strobe i_rd_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .on       (drive_n),
    .k        (k_n),
    .tim      (rd_n_t),
    .strobe_n (mem_rd_n)
  );

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    smc_rd_strobe i_cs_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .on       (drive_n && (sel_n == SELW'(i))),
      .k        (k_n),
      .tim      (cs_n_t),
      .strobe_n (mem_cs_n[i])
    );
  end

  // ---------------- address and byte selects ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_be_n <= '1;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_be_n <= bad_pick ? '1 : ~req_be;
    end else if (at_end) begin
      mem_be_n <= '1;
    end
  end

  // ---------------- data capture and response ----------------
  logic [DATA_W-1:0] data_q;
  logic              rsp_err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_err_q <= 1'b0;
    end else begin
      if (busy_q && !err_q && (k_q == cap_q)) data_q <= mem_rdata;
      rsp_valid <= at_end;
      if (at_end) rsp_err_q <= err_q;
    end
  end

  assign rsp_err  = rsp_err_q;
  assign rsp_data = rsp_err_q ? '0 : data_q;

  // ---------------- assertions ----------------
  // R4
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  // R6
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (k_q != '0)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && err_q) |-> (mem_rd_n && (&mem_cs_n) && (&mem_be_n)));

  // R2
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy_q && (k_q == '0)));

  // R7
  done_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(busy_q));
endmodule

// File: tb/test_smc_read_timer.sv
module test_smc_read_timer;
  import smc_rd_pkg::*;

  localparam int NCS = 4;
  localparam int TW  = TIME_W;
  localparam int FW  = NCS * TW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [FW-1:0] cfg_rd_setup = '0, cfg_rd_pulse = '0, cfg_cs_setup = '0;
  logic [FW-1:0] cfg_cs_pulse = '0, cfg_cycle = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_cs = '0;
  logic [23:0]   req_addr = '0;
  logic [3:0]    req_be = '0;
  logic [23:0]   mem_addr;
  logic [3:0]    mem_be_n;
  logic [3:0]    mem_cs_n;
  logic          mem_rd_n;
  logic [31:0]   mem_rdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_data;
  logic          rsp_err;

  always #5 clk = ~clk;

  smc_read_timer i_smc_read_timer (
    .clk(clk), .rst_n(rst_n),
    .cfg_rd_setup(cfg_rd_setup), .cfg_rd_pulse(cfg_rd_pulse),
    .cfg_cs_setup(cfg_cs_setup), .cfg_cs_pulse(cfg_cs_pulse),
    .cfg_cycle(cfg_cycle),
    .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs),
    .req_addr(req_addr), .req_be(req_be),
    .mem_addr(mem_addr), .mem_be_n(mem_be_n), .mem_cs_n(mem_cs_n),
    .mem_rd_n(mem_rd_n), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  int nvec = 0, nfail = 0;
  bit finished = 0;

  // bench-side timing tables
  int t_rs [NCS], t_rp [NCS], t_css [NCS], t_csp [NCS], t_cy [NCS];

  bit          pend = 0, pend_err = 0;
  logic [31:0] pend_data = '0;
  bit          expect_cont = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic set_slot(input int i, input int rs, input int rp,
                          input int css, input int csp, input int cy);
    t_rs[i] = rs; t_rp[i] = rp; t_css[i] = css; t_csp[i] = csp; t_cy[i] = cy;
    cfg_rd_setup[i*TW +: TW] = TW'(rs);
    cfg_rd_pulse[i*TW +: TW] = TW'(rp);
    cfg_cs_setup[i*TW +: TW] = TW'(css);
    cfg_cs_pulse[i*TW +: TW] = TW'(csp);
    cfg_cycle[i*TW +: TW]    = TW'(cy);
  endtask

  function automatic bit is_bad(input int i);
    return (t_rp[i] == 0) || (t_csp[i] == 0) ||
           (t_cy[i] < t_rs[i] + t_rp[i]) || (t_cy[i] < t_css[i] + t_csp[i]);
  endfunction

  function automatic bit in_win(input int k, input int s, input int p);
    return (k >= s) && (k < s + p);
  endfunction

  // check the response owed by the previous cycle (or its absence)
  task automatic check_rsp();
    if (pend) begin
      chk(rsp_valid == 1'b1, "R7", "rsp_valid", 32'(rsp_valid), 32'd1);
      chk(rsp_err == pend_err, pend_err ? "R10" : "R7", "rsp_err",
          32'(rsp_err), 32'(pend_err));
      chk(rsp_data == pend_data, pend_err ? "R10" : "R7", "rsp_data",
          rsp_data, pend_data);
    end else begin
      chk(rsp_valid == 1'b0, "R7", "rsp_valid idle", 32'(rsp_valid), 32'd0);
    end
    pend = 0;
  endtask

  // called at a falling edge; returns at the falling edge of the last clock
  task automatic run(input int cs, input logic [23:0] a, input logic [3:0] be,
                     input logic [31:0] d);
    bit bad;
    int len;
    bad = is_bad(cs);
    len = bad ? 1 : t_cy[cs];
    req_valid = 1'b1;
    req_cs    = 2'(cs);
    req_addr  = a;
    req_be    = be;
    chk(req_ready == 1'b1, "R2", "ready before accept", 32'(req_ready), 32'd1);
    @(posedge clk);
    for (int k = 0; k < len; k++) begin
      logic       e_rd;
      logic [3:0] e_cs;
      @(negedge clk);
      if (k == 0) begin
        req_valid = 1'b0;
        check_rsp();
      end else begin
        chk(rsp_valid == 1'b0, "R7", "rsp_valid mid", 32'(rsp_valid), 32'd0);
      end
      e_rd = !(!bad && in_win(k, t_rs[cs], t_rp[cs]));
      e_cs = 4'hF;
      if (!bad && in_win(k, t_css[cs], t_csp[cs])) e_cs[cs] = 1'b0;
      chk(mem_rd_n == e_rd, bad ? "R10" : "R3", "mem_rd_n", 32'(mem_rd_n), 32'(e_rd));
      chk(mem_cs_n == e_cs, bad ? "R10" : "R4 R9", "mem_cs_n", 32'(mem_cs_n), 32'(e_cs));
      chk(mem_be_n == (bad ? 4'hF : ~be), bad ? "R10" : "R6", "mem_be_n",
          32'(mem_be_n), 32'(bad ? 4'hF : ~be));
      if (!bad) chk(mem_addr == a, "R6", "mem_addr", 32'(mem_addr), 32'(a));
      chk(req_ready == (k == len - 1), "R5", "ready vs cycle length",
          32'(req_ready), 32'(k == len - 1));
      if (expect_cont)
        chk(!mem_rd_n && !mem_cs_n[cs], "R8", "strobes continuous",
            {30'd0, mem_rd_n, mem_cs_n[cs]}, 32'd0);
      if (!bad && k == t_rs[cs] + t_rp[cs] - 1) mem_rdata = d;
      else mem_rdata = $urandom;
    end
    pend      = 1;
    pend_err  = bad;
    pend_data = bad ? 32'd0 : d;
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      check_rsp();
      chk(mem_rd_n == 1'b1, "R3", "rd idle", 32'(mem_rd_n), 32'd1);
      chk(mem_cs_n == 4'hF, "R4", "cs idle", 32'(mem_cs_n), 32'hF);
      chk(mem_be_n == 4'hF, "R6", "be idle", 32'(mem_be_n), 32'hF);
      chk(req_ready == 1'b1, "R2", "ready idle", 32'(req_ready), 32'd1);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NCS; i++) set_slot(i, 1, 2, 0, 4, 5);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_rd_n == 1'b1, "R1", "rd reset", 32'(mem_rd_n), 32'd1);
    chk(mem_cs_n == 4'hF, "R1", "cs reset", 32'(mem_cs_n), 32'hF);
    chk(mem_be_n == 4'hF, "R1", "be reset", 32'(mem_be_n), 32'hF);
    chk(rsp_valid == 1'b0, "R1", "rsp reset", 32'(rsp_valid), 32'd0);
    chk(req_ready == 1'b1, "R1", "ready reset", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    idle(2);

    // single read, chip select wider than read strobe
    set_slot(0, 1, 3, 0, 5, 6);
    run(0, 24'h12_3456, 4'b1010, 32'hCAFE_0001);
    idle(1);

    // zero setup / zero hold, back-to-back on one chip select (R8)
    set_slot(1, 0, 4, 0, 4, 4);
    expect_cont = 1;
    run(1, 24'h00_0010, 4'hF, 32'h1111_2222);
    run(1, 24'h00_0011, 4'h3, 32'h3333_4444);
    run(1, 24'h00_0012, 4'hC, 32'h5555_6666);
    expect_cont = 0;
    idle(1);

    // back-to-back across chip selects, distinct timings (R9)
    set_slot(2, 2, 2, 1, 4, 7);
    set_slot(3, 2, 1, 1, 4, 7);
    run(0, 24'hAB_CDEF, 4'h1, 32'hDEAD_BEEF);
    run(2, 24'h00_F00D, 4'h8, 32'h0BAD_F00D);
    run(3, 24'hFF_FFFF, 4'h6, 32'h7777_8888);
    run(1, 24'h55_AAAA, 4'h9, 32'h9999_0000);
    idle(1);

    // illegal sets (R10): zero pulse, then cycle shorter than cs window
    set_slot(2, 1, 0, 0, 3, 5);
    run(2, 24'h00_0001, 4'hF, 32'h1234_5678);
    idle(1);
    set_slot(2, 0, 2, 3, 3, 5);
    run(2, 24'h00_0002, 4'hF, 32'h1234_5678);
    run(0, 24'h00_0003, 4'h5, 32'hA5A5_5A5A);
    run(2, 24'h00_0004, 4'hF, 32'h1234_5678);
    idle(1);

    // seeded random streams
    for (int g = 0; g < 8; g++) begin
      for (int i = 0; i < NCS; i++) begin
        int rs, rp, css, csp, cy, mx;
        rs  = $urandom % 4;
        rp  = 1 + $urandom % 5;
        css = $urandom % 4;
        csp = 1 + $urandom % 5;
        mx  = (rs + rp > css + csp) ? rs + rp : css + csp;
        cy  = mx + $urandom % 3;
        if ($urandom % 10 == 0) rp = 0;
        if ($urandom % 10 == 0) cy = mx - 1;
        set_slot(i, rs, rp, css, csp, cy);
      end
      for (int n = 0; n < 30; n++) begin
        run($urandom % NCS, 24'($urandom), 4'($urandom), $urandom);
        if ($urandom % 3 == 0) idle(1 + $urandom % 2);
      end
      idle(1);
    end

    report();
  end
endmodule